// File: doc/BRIEF.md
# Memory-Mapped Cycle Timer

This block is a wide cycle counter that a processor reads and controls through four word slots on a simple load/store bus. The count is split into two halves of `DATA_W` bits. Software reads the halves separately to measure how many clock cycles a stretch of code takes. Software can also read one status slot that reports whether the counter is running. It controls the counter by storing a command word to that same slot: clear, run or halt. The fourth slot is reserved.

The bus has one shared address, a write strobe with write data, and a read strobe. Read data is registered. A read issued on a clock edge returns the value the selected slot held just before that edge, and the bus keeps presenting that value until the next read. After a system reset the count is zero and the counter is stopped.

Top module: `cycle_timer_mmio`

## Requirements
- R1: A system reset clears the count to zero, leaves the counter stopped and drives the read data to zero.
- R2: A read of the slot at offset 0x0 from `BASE_ADDR` (0xFFFFFEF0 by default) returns the low half of the count, bits DATA_W-1:0.
- R3: A read of the slot at offset 0x4 returns the high half of the count, bits 2*DATA_W-1:DATA_W.
- R4: A read of the slot at offset 0x8 returns 1 while the counter runs and 0 while it is stopped.
- R5: A store of value 1 to offset 0x8 clears the count to zero on that edge, even while the counter runs, and leaves the run state as it was.
- R6: A store of value 2 to offset 0x8 starts the counter. A store of value 4 stops it. While running, the count rises by one on each edge after the edge that started it. While stopped, the count holds.
- R7: A store to offset 0x8 of any value other than 1, 2 or 4 (for example 0 or 3) changes neither the count nor the run state.
- R8: Stores to offsets 0x0, 0x4 and 0xC have no effect on the count or the run state.
- R9: Reads of the reserved offset 0xC, of any address outside the 16-byte window, and of any address whose two low bits are not zero return zero.
- R10: The count spans both halves. The low half carries into the high half, and the count wraps to zero after the all-ones value.
- R11: Read data is loaded only on an edge where the read strobe is high. It holds unchanged while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr_en | input | 1 | Store strobe |
| bus_wdata | input | DATA_W | Store data |
| bus_rd_en | input | 1 | Load strobe |
| bus_rdata | output | DATA_W | Registered load data |

## Verification
The bench issues a clear while the counter is running. A design that let the increment win would read back 1 instead of 0, and one that also stopped the counter would report a run state of 0. It stores the non-command values 0 and 3, and a write to a count half. A design that decoded commands by single bits, or that let stores reach the count, would change the count or the run state. A second instance with 4-bit halves runs across its low-half rollover and its full wrap. A missing carry would leave the high half stuck, and a bad wrap would fail to return to zero. The bench also reads misaligned, reserved and out-of-window addresses, where a loose decode would return live count data.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;
  typedef enum logic [1:0] {
    SLOT_LO    = 2'd0,
    SLOT_HI    = 2'd1,
    SLOT_STATE = 2'd2,
    SLOT_RSVD  = 2'd3
  } slot_e;

  localparam int unsigned CMD_CLEAR = 1;
  localparam int unsigned CMD_RUN   = 2;
  localparam int unsigned CMD_HALT  = 4;
endpackage

// File: rtl/ctr_addr_decode.sv
module ctr_addr_decode
  import cyc_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_FEF0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output slot_e             slot
);
  localparam int unsigned WIN_LSB = 4;

  always_comb begin
    hit  = (addr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]) && (addr[1:0] == 2'b00);
    slot = slot_e'(addr[3:2]);
  end
endmodule

// File: rtl/ctr_run_ctrl.sv
module ctr_run_ctrl
  import cyc_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              clear_now,
  output logic              run_q
);
  localparam logic [DATA_W-1:0] CODE_CLR  = DATA_W'(CMD_CLEAR);
  localparam logic [DATA_W-1:0] CODE_RUN  = DATA_W'(CMD_RUN);
  localparam logic [DATA_W-1:0] CODE_HALT = DATA_W'(CMD_HALT);

  logic do_run, do_halt;

  always_comb begin
    clear_now = cmd_we && (cmd_data == CODE_CLR);
    do_run    = cmd_we && (cmd_data == CODE_RUN);
    do_halt   = cmd_we && (cmd_data == CODE_HALT);
  end

  always_ff @(posedge clk) begin
    if (rst)          run_q <= 1'b0;
    else if (do_run)  run_q <= 1'b1;
    else if (do_halt) run_q <= 1'b0;
  end

  // R7
  bad_cmd_keeps_run_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd_data != CODE_RUN && cmd_data != CODE_HALT) |=> $stable(run_q));

  // R1
  reset_stops_chk: assert property (@(posedge clk) rst |=> !run_q);
endmodule

// File: rtl/ctr_count64.sv
module ctr_count64 #(
  parameter int unsigned HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              clear,
  output logic [HALF_W-1:0] cnt_lo,
  output logic [HALF_W-1:0] cnt_hi
);
  localparam int unsigned CNT_W = 2 * HALF_W;
  localparam logic [HALF_W-1:0] HALF_ONE = HALF_W'(1);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

  logic lo_full;
  assign lo_full = &cnt_lo;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else if (run) begin
      cnt_lo <= cnt_lo + HALF_ONE;
      if (lo_full) cnt_hi <= cnt_hi + HALF_ONE;
    end
  end

  // R6
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !clear) |=> $stable({cnt_hi, cnt_lo}));

  // R10
  step_with_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !clear) |=> ({cnt_hi, cnt_lo} == $past({cnt_hi, cnt_lo}) + CNT_ONE));

  // R5
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> ({cnt_hi, cnt_lo} == '0));

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> ({cnt_hi, cnt_lo} == '0));
endmodule

// File: rtl/cycle_timer_mmio.sv
module cycle_timer_mmio
  import cyc_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_FEF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd_en,
  output logic [DATA_W-1:0] bus_rdata
);
  logic              hit;
  slot_e             slot;
  logic              clear_now, run_q;
  logic [DATA_W-1:0] cnt_lo, cnt_hi;
  logic [DATA_W-1:0] rd_mux;

  ctr_addr_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr(bus_addr), .hit(hit), .slot(slot)
  );

  ctr_run_ctrl #(.DATA_W(DATA_W)) u_run (
    .clk(clk), .rst(rst),
    .cmd_we(bus_wr_en && hit && slot == SLOT_STATE),
    .cmd_data(bus_wdata),
    .clear_now(clear_now), .run_q(run_q)
  );

  ctr_count64 #(.HALF_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run_q), .clear(clear_now),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi)
  );

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      unique case (slot)
        SLOT_LO:    rd_mux = cnt_lo;
        SLOT_HI:    rd_mux = cnt_hi;
        SLOT_STATE: rd_mux = {{(DATA_W-1){1'b0}}, run_q};
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            bus_rdata <= '0;
    else if (bus_rd_en) bus_rdata <= rd_mux;
  end

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_en |=> $stable(bus_rdata));

  // R9
  dead_slot_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && (!hit || slot == SLOT_RSVD)) |=> (bus_rdata == '0));

  // R4
  state_bit_only_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && hit && slot == SLOT_STATE) |=> (bus_rdata[DATA_W-1:1] == '0));
endmodule

// File: tb/test_cycle_timer_mmio.sv
module test_cycle_timer_mmio;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] A_LO  = 32'hFFFF_FEF0;
  localparam logic [31:0] A_HI  = 32'hFFFF_FEF4;
  localparam logic [31:0] A_ST  = 32'hFFFF_FEF8;
  localparam logic [31:0] A_RSV = 32'hFFFF_FEFC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] b_addr = '0;
  logic b_we = 1'b0, b_re = 1'b0;
  logic [31:0] b_wd = '0;
  logic [31:0] rd_w;
  logic [3:0]  rd_n;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cycle_timer_mmio i_cycle_timer_mmio (
    .clk(clk), .rst(rst), .bus_addr(b_addr), .bus_wr_en(b_we),
    .bus_wdata(b_wd), .bus_rd_en(b_re), .bus_rdata(rd_w)
  );

  cycle_timer_mmio #(.DATA_W(4)) i_cycle_timer_mmio_narrow (
    .clk(clk), .rst(rst), .bus_addr(b_addr), .bus_wr_en(b_we),
    .bus_wdata(b_wd[3:0]), .bus_rd_en(b_re), .bus_rdata(rd_n)
  );

  // Reference model built from the requirements
  logic [63:0] m_cnt;  logic m_run;  logic [31:0] m_rd;
  logic [7:0]  n_cnt;  logic n_run;  logic [3:0]  n_rd;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt <= '0; m_run <= 1'b0; m_rd <= '0;
      n_cnt <= '0; n_run <= 1'b0; n_rd <= '0;
    end else begin
      if (b_re) begin
        case (b_addr)
          A_LO:    begin m_rd <= m_cnt[31:0];  n_rd <= n_cnt[3:0]; end
          A_HI:    begin m_rd <= m_cnt[63:32]; n_rd <= n_cnt[7:4]; end
          A_ST:    begin m_rd <= {31'd0, m_run}; n_rd <= {3'd0, n_run}; end
          default: begin m_rd <= '0; n_rd <= '0; end
        endcase
      end
      if (b_we && b_addr == A_ST && b_wd == 32'd1) m_cnt <= '0;
      else if (m_run) m_cnt <= m_cnt + 64'd1;
      if (b_we && b_addr == A_ST && b_wd == 32'd2) m_run <= 1'b1;
      else if (b_we && b_addr == A_ST && b_wd == 32'd4) m_run <= 1'b0;
      if (b_we && b_addr == A_ST && b_wd[3:0] == 4'd1) n_cnt <= '0;
      else if (n_run) n_cnt <= n_cnt + 8'd1;
      if (b_we && b_addr == A_ST && b_wd[3:0] == 4'd2) n_run <= 1'b1;
      else if (b_we && b_addr == A_ST && b_wd[3:0] == 4'd4) n_run <= 1'b0;
    end
  end

  typedef struct packed {
    logic        we;
    logic        re;
    logic [31:0] addr;
    logic [31:0] wd;
    logic [7:0]  idle;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, A_ST,  32'd0,        8'd0, 4'd4},  // R4 stopped
    '{1'b1, 1'b0, A_ST,  32'd2,        8'd0, 4'd6},  // R6 start
    '{1'b0, 1'b1, A_ST,  32'd0,        8'd5, 4'd4},  // R4 running
    '{1'b0, 1'b1, A_LO,  32'd0,        8'd0, 4'd2},  // R2
    '{1'b0, 1'b1, A_HI,  32'd0,        8'd0, 4'd3},  // R3
    '{1'b1, 1'b0, A_LO,  32'hDEAD,     8'd0, 4'd8},  // R8 store to low half
    '{1'b0, 1'b1, A_LO,  32'd0,        8'd0, 4'd8},
    '{1'b1, 1'b0, A_ST,  32'd3,        8'd0, 4'd7},  // R7 illegal code
    '{1'b0, 1'b1, A_ST,  32'd0,        8'd0, 4'd7},
    '{1'b1, 1'b0, A_ST,  32'd4,        8'd3, 4'd6},  // R6 stop
    '{1'b0, 1'b1, A_LO,  32'd0,        8'd4, 4'd6},
    '{1'b0, 1'b1, A_LO,  32'd0,        8'd0, 4'd6},  // R6 held
    '{1'b1, 1'b0, A_ST,  32'd1,        8'd0, 4'd5},  // R5 clear stopped
    '{1'b0, 1'b1, A_ST,  32'd0,        8'd0, 4'd5},
    '{1'b0, 1'b1, A_LO,  32'd0,        8'd0, 4'd5},
    '{1'b1, 1'b0, A_ST,  32'd0,        8'd0, 4'd7},  // R7 zero code
    '{1'b1, 1'b0, A_RSV, 32'hFFFF,     8'd0, 4'd8},  // R8 reserved store
    '{1'b0, 1'b1, A_RSV, 32'd0,        8'd0, 4'd9},  // R9
    '{1'b0, 1'b1, 32'hFFFF_FF00, 32'd0, 8'd0, 4'd9}, // R9 out of window
    '{1'b1, 1'b0, A_ST,  32'd2,        8'd6, 4'd6},  // R6 restart
    '{1'b0, 1'b1, 32'hFFFF_FEF2, 32'd0, 8'd0, 4'd9}, // R9 misaligned
    '{1'b1, 1'b0, A_ST,  32'd1,        8'd0, 4'd5},  // R5 clear running
    '{1'b0, 1'b1, A_LO,  32'd0,        8'd0, 4'd5}
  };

  task automatic check(input string tag);
    n_tests++;
    if (rd_w !== m_rd) begin
      n_fail++;
      $display("FAIL %s wide: actual %h expected %h", tag, rd_w, m_rd);
    end
    n_tests++;
    if (rd_n !== n_rd) begin
      n_fail++;
      $display("FAIL %s narrow: actual %h expected %h", tag, rd_n, n_rd);
    end
  endtask

  task automatic bus_op(input logic we, input logic re, input logic [31:0] a,
                        input logic [31:0] wd, input string tag);
    b_we = we; b_re = re; b_addr = a; b_wd = wd;
    @(negedge clk);
    b_we = 1'b0; b_re = 1'b0;
    if (re) check(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    // R1 reset values
    check("R1");
    rst = 1'b0;
    bus_op(1'b0, 1'b1, A_ST, 32'd0, "R1");
    bus_op(1'b0, 1'b1, A_LO, 32'd0, "R1");

    for (int v = 0; v < NV; v++) begin
      bus_op(VECS[v].we, VECS[v].re, VECS[v].addr, VECS[v].wd,
             $sformatf("R%0d vec%0d", VECS[v].req, v));
      idle(int'(VECS[v].idle));
    end

    // R11 data holds while read strobe low
    bus_op(1'b0, 1'b1, A_LO, 32'd0, "R11");
    idle(7);
    check("R11");

    // R10 narrow instance crosses its low-half rollover and full wrap
    bus_op(1'b1, 1'b0, A_ST, 32'd1, "R10");
    idle(12);
    for (int k = 0; k < 8; k++) begin
      bus_op(1'b0, 1'b1, A_HI, 32'd0, "R10 carry");
      bus_op(1'b0, 1'b1, A_LO, 32'd0, "R10 carry");
    end
    idle(220);
    for (int k = 0; k < 10; k++) begin
      bus_op(1'b0, 1'b1, A_HI, 32'd0, "R10 wrap");
      bus_op(1'b0, 1'b1, A_LO, 32'd0, "R10 wrap");
    end

    // R1 reset while running
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    check("R1");
    bus_op(1'b0, 1'b1, A_ST, 32'd0, "R1");
    idle(3);
    bus_op(1'b0, 1'b1, A_LO, 32'd0, "R1");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule